// File: doc/BRIEF.md
# Test Access Port State Machine

This block is the sixteen-state sequencer behind a boundary-scan test port. It is clocked by the test clock. On each rising edge it moves to a new state chosen only by the present state and the mode-select input `tms`. The other test logic needs to know which scan phase is active. The block reports this through a 4-bit state code and a 16-bit one-hot state vector. It also drives seven strobes: capture, shift and update for the data-register path and for the instruction-register path, plus a test-logic reset flag.

The sequencer has two scan branches of seven states each, one for data and one for instruction. Each branch runs capture, shift and update in that order. A branch can pause and resume in the middle of a shift through its exit and pause states. The instruction and data registers, the instruction decoding and the pin cells are outside this block.

Two resets force the reset state. The first is a synchronous active-high reset, `rst`. The second is an asynchronous active-low test reset, `trst_n`, which is tied high when it is not used. A parameter chooses how the state is stored: a 4-bit binary register or a 16-bit one-hot register. The port behaviour is the same for both.

Top module: `tap_sequencer`

## Requirements
- R1: While `rst` is high at a rising clock edge, the next state is Test-Logic-Reset (code 0), with `state_onehot` = 16'h0001 and `logic_reset` high.
- R2: Pulling `trst_n` low puts the sequencer in Test-Logic-Reset at once, with no clock edge needed. It stays there as long as `trst_n` is low.
- R3: From Test-Logic-Reset, `tms`=1 stays and `tms`=0 moves to Run-Test/Idle. From Run-Test/Idle, `tms`=0 stays and `tms`=1 moves to Select-DR.
- R4: From Select-DR, `tms`=0 moves to Capture-DR and `tms`=1 moves to Select-IR. From Select-IR, `tms`=0 moves to Capture-IR and `tms`=1 returns to Test-Logic-Reset.
- R5: The same rules hold in both branches. Capture moves to Shift on 0 and to Exit1 on 1. Shift holds on 0 and moves to Exit1 on 1. Exit1 moves to Pause on 0 and to Update on 1.
- R6: In both branches, Pause holds on 0 and moves to Exit2 on 1. Exit2 returns to Shift on 0 and moves to Update on 1.
- R7: Update-DR and Update-IR both move to Run-Test/Idle on `tms`=0 and to Select-DR on `tms`=1.
- R8: Five rising edges with `tms` high reach Test-Logic-Reset from any state.
- R9: `state_code` uses these codes: 0 Test-Logic-Reset, 1 Run-Test/Idle, 2 Select-DR, 3 Capture-DR, 4 Shift-DR, 5 Exit1-DR, 6 Pause-DR, 7 Exit2-DR, 8 Update-DR, 9 Select-IR, 10 Capture-IR, 11 Shift-IR, 12 Exit1-IR, 13 Pause-IR, 14 Exit2-IR, 15 Update-IR. Bit n of `state_onehot` is the only bit set, where n is the code.
- R10: Each strobe is high in exactly one state and low in all others: `logic_reset` in code 0, `capture_dr` in 3, `shift_dr` in 4, `update_dr` in 8, `capture_ir` in 10, `shift_ir` in 11, `update_ir` in 15. At most one strobe is high at a time.
- R11: With `ONE_HOT`=1 (one-hot storage) and `ONE_HOT`=0 (binary storage), every output matches cycle for cycle under the same inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock; state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset to Test-Logic-Reset |
| trst_n | input | 1 | Asynchronous active-low test reset; tie high if unused |
| tms | input | 1 | Mode select that steers the state graph |
| state_code | output | 4 | Binary code of the present state |
| state_onehot | output | 16 | One-hot view of the present state |
| logic_reset | output | 1 | High in Test-Logic-Reset |
| capture_dr | output | 1 | High in Capture-DR |
| shift_dr | output | 1 | High in Shift-DR |
| update_dr | output | 1 | High in Update-DR |
| capture_ir | output | 1 | High in Capture-IR |
| shift_ir | output | 1 | High in Shift-IR |
| update_ir | output | 1 | High in Update-IR |

## Verification
The bench builds two copies of the block side by side, one with `ONE_HOT`=1 and one with `ONE_HOT`=0. Both run from the same `tms`, `rst` and `trst_n`, so both storage variants and their encode and decode paths are tested. Both copies are compared with one table-driven model. The bench first sends the sequencer home with five high `tms` edges. It then steers the sequencer into each of the sixteen states and applies both values of `tms` there. After that it holds the shift states for many cycles, asserts both resets in the middle of scans, and runs a long walk with random `tms`.

// File: rtl/tapseq_pkg.sv
`timescale 1ns/1ps
package tapseq_pkg;

    localparam int NUM_STATES = 16;
    localparam int CODE_W     = $clog2(NUM_STATES);

    // Codes: the data branch is 2..8 and the instruction branch is 9..15.
    typedef enum logic [CODE_W-1:0] {
        ST_TLR  = 4'd0,
        ST_IDLE = 4'd1,
        ST_DSEL = 4'd2,
        ST_DCAP = 4'd3,
        ST_DSHF = 4'd4,
        ST_DEX1 = 4'd5,
        ST_DPAU = 4'd6,
        ST_DEX2 = 4'd7,
        ST_DUPD = 4'd8,
        ST_ISEL = 4'd9,
        ST_ICAP = 4'd10,
        ST_ISHF = 4'd11,
        ST_IEX1 = 4'd12,
        ST_IPAU = 4'd13,
        ST_IEX2 = 4'd14,
        ST_IUPD = 4'd15
    } tap_state_e;

    typedef struct packed {
        logic logic_reset;
        logic cap_dr;
        logic shf_dr;
        logic upd_dr;
        logic cap_ir;
        logic shf_ir;
        logic upd_ir;
    } tap_strobe_t;

    localparam logic [NUM_STATES-1:0] ONEHOT_LSB = {{(NUM_STATES-1){1'b0}}, 1'b1};

    // The next state depends only on the present state and the mode-select bit.
    function automatic tap_state_e step_state(input tap_state_e cur, input logic tms);
        tap_state_e nxt;
        nxt = ST_TLR;
        case (cur)
            ST_TLR:  nxt = tms ? ST_TLR  : ST_IDLE;
            ST_IDLE: nxt = tms ? ST_DSEL : ST_IDLE;
            ST_DSEL: nxt = tms ? ST_ISEL : ST_DCAP;
            ST_DCAP: nxt = tms ? ST_DEX1 : ST_DSHF;
            ST_DSHF: nxt = tms ? ST_DEX1 : ST_DSHF;
            ST_DEX1: nxt = tms ? ST_DUPD : ST_DPAU;
            ST_DPAU: nxt = tms ? ST_DEX2 : ST_DPAU;
            ST_DEX2: nxt = tms ? ST_DUPD : ST_DSHF;
            ST_DUPD: nxt = tms ? ST_DSEL : ST_IDLE;
            ST_ISEL: nxt = tms ? ST_TLR  : ST_ICAP;
            ST_ICAP: nxt = tms ? ST_IEX1 : ST_ISHF;
            ST_ISHF: nxt = tms ? ST_IEX1 : ST_ISHF;
            ST_IEX1: nxt = tms ? ST_IUPD : ST_IPAU;
            ST_IPAU: nxt = tms ? ST_IEX2 : ST_IPAU;
            ST_IEX2: nxt = tms ? ST_IUPD : ST_ISHF;
            ST_IUPD: nxt = tms ? ST_DSEL : ST_IDLE;
            default: nxt = ST_TLR;
        endcase
        return nxt;
    endfunction

    function automatic logic [NUM_STATES-1:0] to_onehot(input tap_state_e s);
        return ONEHOT_LSB << s;
    endfunction

endpackage

// File: rtl/tapseq_next.sv
`timescale 1ns/1ps
module tapseq_next
    import tapseq_pkg::*;
(
    input  tap_state_e cur_state,
    input  logic       tms,
    output tap_state_e nxt_state
);

    assign nxt_state = step_state(cur_state, tms);

endmodule

// File: rtl/tapseq_state_reg.sv
`timescale 1ns/1ps
module tapseq_state_reg
    import tapseq_pkg::*;
#(
    parameter bit ONE_HOT = 1'b1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  trst_n,
    input  tap_state_e            nxt_state,
    output tap_state_e            cur_state,
    output logic [NUM_STATES-1:0] cur_onehot
);

    generate
        if (ONE_HOT) begin : g_onehot
            logic [NUM_STATES-1:0] oh_q;
            logic [CODE_W-1:0]     enc;

            always_ff @(posedge clk or negedge trst_n) begin
                if (!trst_n) begin
                    oh_q <= ONEHOT_LSB;
                end else if (rst) begin
                    oh_q <= ONEHOT_LSB;
                end else begin
                    oh_q <= to_onehot(nxt_state);
                end
            end

            // Turn the single set bit back into its index.
            always_comb begin
                enc = '0;
                for (int i = 0; i < NUM_STATES; i++) begin
                    if (oh_q[i]) begin
                        enc = enc | CODE_W'(i);
                    end
                end
            end

            assign cur_onehot = oh_q;
            assign cur_state  = tap_state_e'(enc);
        end else begin : g_binary
            tap_state_e st_q;

            always_ff @(posedge clk or negedge trst_n) begin
                if (!trst_n) begin
                    st_q <= ST_TLR;
                end else if (rst) begin
                    st_q <= ST_TLR;
                end else begin
                    st_q <= nxt_state;
                end
            end

            assign cur_state  = st_q;
            assign cur_onehot = to_onehot(st_q);
        end
    endgenerate

endmodule

// File: rtl/tapseq_strobe_dec.sv
`timescale 1ns/1ps
module tapseq_strobe_dec
    import tapseq_pkg::*;
(
    input  logic [NUM_STATES-1:0] cur_onehot,
    output tap_strobe_t           strobes
);

    always_comb begin
        strobes.logic_reset = cur_onehot[ST_TLR];
        strobes.cap_dr      = cur_onehot[ST_DCAP];
        strobes.shf_dr      = cur_onehot[ST_DSHF];
        strobes.upd_dr      = cur_onehot[ST_DUPD];
        strobes.cap_ir      = cur_onehot[ST_ICAP];
        strobes.shf_ir      = cur_onehot[ST_ISHF];
        strobes.upd_ir      = cur_onehot[ST_IUPD];
    end

endmodule

// File: rtl/tap_sequencer.sv
`timescale 1ns/1ps
module tap_sequencer
    import tapseq_pkg::*;
#(
    parameter bit ONE_HOT = 1'b1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  trst_n,
    input  logic                  tms,
    output logic [CODE_W-1:0]     state_code,
    output logic [NUM_STATES-1:0] state_onehot,
    output logic                  logic_reset,
    output logic                  capture_dr,
    output logic                  shift_dr,
    output logic                  update_dr,
    output logic                  capture_ir,
    output logic                  shift_ir,
    output logic                  update_ir
);

    tap_state_e            cur_state;
    tap_state_e            nxt_state;
    logic [NUM_STATES-1:0] cur_onehot;
    tap_strobe_t           strobes;

    tapseq_next u_next (
        .cur_state (cur_state),
        .tms       (tms),
        .nxt_state (nxt_state)
    );

    tapseq_state_reg #(
        .ONE_HOT (ONE_HOT)
    ) u_state (
        .clk        (clk),
        .rst        (rst),
        .trst_n     (trst_n),
        .nxt_state  (nxt_state),
        .cur_state  (cur_state),
        .cur_onehot (cur_onehot)
    );

    tapseq_strobe_dec u_dec (
        .cur_onehot (cur_onehot),
        .strobes    (strobes)
    );

    assign state_code   = cur_state;
    assign state_onehot = cur_onehot;
    assign logic_reset  = strobes.logic_reset;
    assign capture_dr   = strobes.cap_dr;
    assign shift_dr     = strobes.shf_dr;
    assign update_dr    = strobes.upd_dr;
    assign capture_ir   = strobes.cap_ir;
    assign shift_ir     = strobes.shf_ir;
    assign update_ir    = strobes.upd_ir;

endmodule

// File: rtl/tap_sequencer_chk.sv
`timescale 1ns/1ps
module tap_sequencer_chk
    import tapseq_pkg::*;
(
    input logic                  clk,
    input logic                  rst,
    input logic                  trst_n,
    input logic                  tms,
    input logic [CODE_W-1:0]     state_code,
    input logic [NUM_STATES-1:0] state_onehot,
    input logic                  logic_reset,
    input logic                  capture_dr,
    input logic                  shift_dr,
    input logic                  update_dr,
    input logic                  capture_ir,
    input logic                  shift_ir,
    input logic                  update_ir
);

    // Counts back-to-back edges with tms high, saturating at five.
    logic [2:0] ones_q;
    always_ff @(posedge clk or negedge trst_n) begin
        if (!trst_n) begin
            ones_q <= 3'd0;
        end else if (rst) begin
            ones_q <= 3'd0;
        end else if (tms) begin
            ones_q <= (ones_q == 3'd5) ? 3'd5 : ones_q + 3'd1;
        end else begin
            ones_q <= 3'd0;
        end
    end

    // R1
    sync_reset_chk: assert property (@(posedge clk) disable iff (!trst_n)
        rst |=> (state_code == ST_TLR && logic_reset));

    // R2
    async_reset_chk: assert property (@(posedge clk) disable iff (rst)
        !trst_n |-> (logic_reset && state_code == ST_TLR));

    // R3
    tlr_hold_chk: assert property (@(posedge clk) disable iff (rst || !trst_n)
        (state_code == ST_TLR && tms) |=> state_code == ST_TLR);

    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst || !trst_n)
        (state_code == ST_IDLE && !tms) |=> state_code == ST_IDLE);

    // R4
    irsel_exit_chk: assert property (@(posedge clk) disable iff (rst || !trst_n)
        (state_code == ST_ISEL && tms) |=> logic_reset);

    // R5
    dr_capture_next_chk: assert property (@(posedge clk) disable iff (rst || !trst_n)
        capture_dr |=> (shift_dr || state_code == ST_DEX1));

    // R5
    ir_capture_next_chk: assert property (@(posedge clk) disable iff (rst || !trst_n)
        capture_ir |=> (shift_ir || state_code == ST_IEX1));

    // R6
    dr_pause_hold_chk: assert property (@(posedge clk) disable iff (rst || !trst_n)
        (state_code == ST_DPAU && !tms) |=> state_code == ST_DPAU);

    // R6
    ir_exit2_resume_chk: assert property (@(posedge clk) disable iff (rst || !trst_n)
        (state_code == ST_IEX2 && !tms) |=> shift_ir);

    // R7
    update_next_chk: assert property (@(posedge clk) disable iff (rst || !trst_n)
        (update_dr || update_ir) |=> (state_code == ST_IDLE || state_code == ST_DSEL));

    // R8
    five_ones_chk: assert property (@(posedge clk) disable iff (rst || !trst_n)
        (ones_q == 3'd5) |-> logic_reset);

    // R9
    onehot_match_chk: assert property (@(posedge clk) disable iff (rst || !trst_n)
        ($countones(state_onehot) == 1 && state_onehot[state_code]));

    // R10
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst || !trst_n)
        $onehot0({logic_reset, capture_dr, shift_dr, update_dr,
                  capture_ir, shift_ir, update_ir}));

endmodule

bind tap_sequencer tap_sequencer_chk u_chk (.*);

// File: tb/tap_sequencer_bench.sv
`timescale 1ns/1ps
module tap_sequencer_bench;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst, trst_n, tms;

    logic [3:0]  a_code, b_code;
    logic [15:0] a_oh, b_oh;
    logic a_lr, a_cd, a_sd, a_ud, a_ci, a_si, a_ui;
    logic b_lr, b_cd, b_sd, b_ud, b_ci, b_si, b_ui;
    wire  [6:0] a_stb = {a_lr, a_cd, a_sd, a_ud, a_ci, a_si, a_ui};
    wire  [6:0] b_stb = {b_lr, b_cd, b_sd, b_ud, b_ci, b_si, b_ui};

    tap_sequencer #(.ONE_HOT(1'b1)) u_tap_sequencer (
        .clk(clk), .rst(rst), .trst_n(trst_n), .tms(tms),
        .state_code(a_code), .state_onehot(a_oh),
        .logic_reset(a_lr), .capture_dr(a_cd), .shift_dr(a_sd), .update_dr(a_ud),
        .capture_ir(a_ci), .shift_ir(a_si), .update_ir(a_ui)
    );

    tap_sequencer #(.ONE_HOT(1'b0)) u_tap_sequencer_bin (
        .clk(clk), .rst(rst), .trst_n(trst_n), .tms(tms),
        .state_code(b_code), .state_onehot(b_oh),
        .logic_reset(b_lr), .capture_dr(b_cd), .shift_dr(b_sd), .update_dr(b_ud),
        .capture_ir(b_ci), .shift_ir(b_si), .update_ir(b_ui)
    );

    // Model: the successor of each state code for tms = 0 and for tms = 1.
    int nxt0 [16] = '{1, 1, 3, 4, 4, 6, 6, 4, 1, 10, 11, 11, 13, 13, 11, 1};
    int nxt1 [16] = '{0, 2, 9, 5, 5, 8, 7, 8, 2, 0, 12, 12, 15, 14, 15, 2};
    // The tms bits (first bit in the LSB) that lead from reset to each state.
    int plen [16] = '{0, 1, 2, 3, 4, 4, 5, 6, 5, 3, 4, 5, 5, 6, 7, 6};
    int pbits[16] = '{'h0, 'h0, 'h2, 'h2, 'h2, 'hA, 'hA, 'h2A, 'h1A,
                      'h6, 'h6, 'h6, 'h16, 'h16, 'h56, 'h36};

    int mstate;
    int checks;
    int errors;
    bit done;

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int exp_stb(input int s);
        return int'({s == 0, s == 3, s == 4, s == 8, s == 10, s == 11, s == 15});
    endfunction

    function automatic string tag_of(input int s);
        case (s)
            0, 1:                   return "R3";
            2, 9:                   return "R4";
            3, 4, 5, 10, 11, 12:    return "R5";
            6, 7, 13, 14:           return "R6";
            default:                return "R7";
        endcase
    endfunction

    task automatic verify(input string req);
        chk(req,   "code A",    int'(a_code), mstate);
        chk("R9",  "onehot A",  int'(a_oh),   1 << mstate);
        chk("R10", "strobes A", int'(a_stb),  exp_stb(mstate));
        chk("R11", "code B",    int'(b_code), mstate);
        chk("R11", "onehot B",  int'(b_oh),   1 << mstate);
        chk("R11", "strobes B", int'(b_stb),  exp_stb(mstate));
    endtask

    task automatic step(input logic t);
        string req;
        int prev;
        prev = mstate;
        tms = t;
        @(posedge clk);
        if (rst) begin
            mstate = 0;
            req = "R1";
        end else if (!trst_n) begin
            mstate = 0;
            req = "R2";
        end else begin
            mstate = t ? nxt1[prev] : nxt0[prev];
            req = tag_of(prev);
        end
        #2;
        verify(req);
    endtask

    task automatic go_home();
        repeat (5) step(1'b1);
        chk("R8", "code A after five ones", int'(a_code), 0);
        chk("R8", "code B after five ones", int'(b_code), 0);
    endtask

    task automatic go_to(input int s);
        go_home();
        for (int i = 0; i < plen[s]; i++) begin
            step(logic'((pbits[s] >> i) & 1));
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog (all requirements): actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        checks = 0;
        errors = 0;
        done   = 1'b0;
        mstate = 0;
        rst    = 1'b1;
        trst_n = 1'b1;
        tms    = 1'b0;

        // R1: reset state, with tms at both values
        step(1'b0);
        step(1'b1);
        chk("R1", "logic_reset under rst", int'(a_lr), 1);
        rst = 1'b0;

        // R3..R7: every state, both tms branches
        for (int s = 0; s < 16; s++) begin
            for (int b = 0; b < 2; b++) begin
                go_to(s);
                step(logic'(b));
            end
        end

        // R5: long holds in both shift states
        go_to(4);
        repeat (20) step(1'b0);
        go_to(11);
        repeat (20) step(1'b0);
        // R6: long hold in pause-IR, then resume shift
        go_to(13);
        repeat (12) step(1'b0);
        step(1'b1);
        step(1'b0);

        // R2: asynchronous test reset in the middle of an instruction shift
        go_to(11);
        trst_n = 1'b0;
        #1;
        mstate = 0;
        verify("R2");
        step(1'b0);
        step(1'b1);
        trst_n = 1'b1;
        step(1'b0);
        chk("R2", "leaves reset after release", int'(a_code), 1);

        // R1: synchronous reset in the middle of a data pause
        go_to(6);
        rst = 1'b1;
        step(1'b0);
        rst = 1'b0;
        step(1'b0);

        // Random walks: balanced first, then weighted toward tms = 1
        repeat (1500) step(logic'($urandom_range(0, 1)));
        repeat (1500) step(logic'($urandom_range(0, 3) != 0));

        finish_run();
    end

endmodule